// File: doc/BRIEF.md
# Compressed Check Message Regenerator

This block turns the compact result of a min-sum check-node computation back into one check-to-variable message per edge. For each earlier block row (layer) it keeps one record: the smallest magnitude, the second smallest magnitude (both already offset-corrected), the edge position of the smallest, and the product of the input signs. It also keeps a one-bit sign queue that holds the sign of each edge's earlier variable-to-check message, in edge order.

When a burst is started for a chosen record, the block emits k messages, one per clock. Each message is a 5-bit two's complement value. The magnitude comes from the record and the sign comes from the record's sign product combined with the next queued edge sign. Edges that fall in a null sub-block (edge index below the block row index) are forced to zero. A whole burst can also be forced to zero for the first sub-iteration, when no old message exists yet. The layered decoder subtracts these old messages from its running sums.

Top module: `crm_regen`

## Requirements
- R1: After a synchronous active-low reset, `r_valid` and `busy` are 0, every record holds zero fields, and the sign queue is empty.
- R2: A cycle with `rec_wr` high stores `{rec_m1, rec_m2, rec_idx, rec_sign}` into record slot `rec_slot`. There are LAYERS-1 slots (4 by default), and no other slot changes.
- R3: `go` is accepted only when `busy` is low and `1 <= go_len <= K_MAX`. Any other `go` is ignored and does not disturb a running burst.
- R4: If `go` is accepted at rising edge t, `busy` is high from t until the edge that emits the last message. Edge e (0..go_len-1) is presented with `r_valid` high after rising edge t+1+e, with `r_edge` = e. `r_valid` is low in every other cycle.
- R5: The output magnitude is the record's second minimum when `r_edge` equals the stored index, and the record's first minimum otherwise.
- R6: The output sign is the record's sign product XOR the sign bit popped for that edge. A set sign gives the two's complement negation of the magnitude (MAG_W+1 bits wide).
- R7: With block row `go_row`, every edge with index below `go_row` outputs 0.
- R8: A burst started with `go_first` high outputs 0 on every edge.
- R9: Each emitted edge pops one bit from the sign queue, including zero-forced edges. An empty queue supplies sign 0. `sgn_push` appends `sgn_bit` unless the queue already holds K_MAX bits (judged before that cycle's pop), in which case the bit is dropped.
- R10: The record is read at each emitted edge, so a write to the active slot during a burst takes effect from the next emitted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_wr | input | 1 | Write a record |
| rec_slot | input | SLOT_W | Record slot to write |
| rec_m1 | input | MAG_W | Smallest magnitude, offset-corrected |
| rec_m2 | input | MAG_W | Second smallest magnitude, offset-corrected |
| rec_idx | input | IDX_W | Edge index of the smallest magnitude |
| rec_sign | input | 1 | Product of input signs (1 = negative) |
| sgn_push | input | 1 | Append one edge sign to the queue |
| sgn_bit | input | 1 | Edge sign to append (1 = negative) |
| go | input | 1 | Start a burst |
| go_slot | input | SLOT_W | Record slot used by the burst |
| go_row | input | ROW_W | Block row index for null-block forcing |
| go_len | input | KLEN_W | Number of edges k |
| go_first | input | 1 | First sub-iteration: force all outputs to zero |
| r_valid | output | 1 | Message valid |
| r_edge | output | IDX_W | Edge index of the message |
| r_msg | output | MAG_W+1 | Regenerated message, two's complement |
| busy | output | 1 | Burst in progress |

## Verification
The hardest situation to reach is the interaction of the sign queue with bursts. The queue has to overflow, then be drained by zero-forced edges, and be pushed and popped in the same cycle, all while a record is rewritten mid-burst. The stimulus first fills the queue past K_MAX and runs a full-length burst whose minimum sits on the final edge. It then overlaps pushes and a record rewrite with a running burst that has null-block edges. A behavioural reference built from a bit queue and integer arrays is compared against the outputs on every clock.

// File: rtl/crm_pkg.sv
// Shared sizing and record type for the check message regenerator.
// Assumes K_MAX >= 2 and LAYERS >= 3.
package crm_pkg;
    parameter int unsigned MAG_W  = 4;
    parameter int unsigned K_MAX  = 25;
    parameter int unsigned LAYERS = 5;

    localparam int unsigned SLOTS  = LAYERS - 1;
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int unsigned IDX_W  = $clog2(K_MAX);
    localparam int unsigned ROW_W  = $clog2(LAYERS);
    localparam int unsigned KLEN_W = $clog2(K_MAX + 1);
    localparam int unsigned MSG_W  = MAG_W + 1;
    localparam int unsigned CNT_W  = $clog2(K_MAX + 1);

    typedef struct packed {
        logic [MAG_W-1:0] m1;
        logic [MAG_W-1:0] m2;
        logic [IDX_W-1:0] idx;
        logic             csign;
    } fs_rec_t;
endpackage

// File: rtl/crm_fs_bank.sv
// Register bank with one compact check record per earlier block row.
// Write is synchronous; read is combinational from the stored slot.
module crm_fs_bank
    import crm_pkg::*;
#(
    parameter int unsigned N_SLOT = SLOTS,
    parameter int unsigned SW     = SLOT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  fs_rec_t       wr_rec,
    input  logic [SW-1:0] rd_slot,
    output fs_rec_t       rd_rec
);
    fs_rec_t slot_q [N_SLOT];

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        // Each slot loads only when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (wr_en && (int'(wr_slot) == s)) begin
                slot_q[s] <= wr_rec;
            end
        end
    end

    // Read mux; out-of-range addresses read zero.
    always_comb begin
        rd_rec = '0;
        for (int s = 0; s < N_SLOT; s++) begin
            if (int'(rd_slot) == s) rd_rec = slot_q[s];
        end
    end
endmodule

// File: rtl/crm_sign_fifo.sv
// One-bit sign queue holding edge signs in arrival order.
// Full is judged before a same-cycle pop; an empty queue reads 0.
module crm_sign_fifo #(
    parameter int unsigned DEPTH = 25,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          push_bit,
    input  logic          pop,
    output logic          head_bit,
    output logic [CW-1:0] count
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] mem_q;
    logic [PTR_W-1:0] wr_q, rd_q;
    logic             acc_push, do_pop;

    // Accept and pop qualifiers.
    always_comb begin
        acc_push = push && (int'(count) < DEPTH);
        do_pop   = pop && (count != '0);
        head_bit = (count != '0) ? mem_q[rd_q] : 1'b0;
    end

    // Storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (acc_push) begin
                mem_q[wr_q] <= push_bit;
                wr_q <= (int'(wr_q) == DEPTH - 1) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (int'(rd_q) == DEPTH - 1) ? '0 : rd_q + 1'b1;
            end
            case ({acc_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/crm_edge_select.sv
// Combinational per-edge message former: magnitude pick, sign
// recovery and zero forcing. Assumes magnitudes are unsigned.
module crm_edge_select
    import crm_pkg::*;
(
    input  fs_rec_t          rec,
    input  logic [IDX_W-1:0] edge_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             zero_all,
    input  logic             qsign,
    output logic [MSG_W-1:0] msg
);
    logic [MAG_W-1:0] mag;
    logic [MSG_W-1:0] smag;
    logic             neg, null_blk;

    // Select magnitude, recover sign, apply zero forcing.
    always_comb begin
        null_blk = zero_all || (int'(edge_i) < int'(row_i));
        mag      = (edge_i == rec.idx) ? rec.m2 : rec.m1;
        neg      = rec.csign ^ qsign;
        smag     = {1'b0, mag};
        if (null_blk)  msg = '0;
        else if (neg)  msg = '0 - smag;
        else           msg = smag;
    end
endmodule

// File: rtl/crm_regen.sv
// Top of the check message regenerator. Sequences k edges per burst,
// reading one record and popping one sign bit per edge; the output
// stage is registered. Assumes the caller pushes edge signs in order.
module crm_regen
    import crm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_wr,
    input  logic [SLOT_W-1:0] rec_slot,
    input  logic [MAG_W-1:0]  rec_m1,
    input  logic [MAG_W-1:0]  rec_m2,
    input  logic [IDX_W-1:0]  rec_idx,
    input  logic              rec_sign,
    input  logic              sgn_push,
    input  logic              sgn_bit,
    input  logic              go,
    input  logic [SLOT_W-1:0] go_slot,
    input  logic [ROW_W-1:0]  go_row,
    input  logic [KLEN_W-1:0] go_len,
    input  logic              go_first,
    output logic              r_valid,
    output logic [IDX_W-1:0]  r_edge,
    output logic [MSG_W-1:0]  r_msg,
    output logic              busy
);
    logic              busy_q, zero_q, accept, last_edge, qsign;
    logic [IDX_W-1:0]  cnt_q;
    logic [KLEN_W-1:0] len_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ROW_W-1:0]  row_q;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [MSG_W-1:0]  sel_msg;
    fs_rec_t           wr_rec, rd_rec;

    // Start qualification and end-of-burst detection.
    always_comb begin
        accept    = go && !busy_q && (go_len != '0) && (int'(go_len) <= K_MAX);
        last_edge = (int'(cnt_q) + 1 == int'(len_q));
        wr_rec    = '{m1: rec_m1, m2: rec_m2, idx: rec_idx, csign: rec_sign};
        busy      = busy_q;
    end

    crm_fs_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rec_wr),
        .wr_slot (rec_slot),
        .wr_rec  (wr_rec),
        .rd_slot (slot_q),
        .rd_rec  (rd_rec)
    );

    crm_sign_fifo #(.DEPTH(K_MAX), .CW(CNT_W)) u_sfifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (sgn_push),
        .push_bit (sgn_bit),
        .pop      (busy_q),
        .head_bit (qsign),
        .count    (fifo_cnt)
    );

    crm_edge_select u_sel (
        .rec      (rd_rec),
        .edge_i   (cnt_q),
        .row_i    (row_q),
        .zero_all (zero_q),
        .qsign    (qsign),
        .msg      (sel_msg)
    );

    // Burst sequencer: latches burst setup and walks the edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            len_q  <= '0;
            slot_q <= '0;
            row_q  <= '0;
            zero_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_edge) busy_q <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            len_q  <= go_len;
            slot_q <= go_slot;
            row_q  <= go_row;
            zero_q <= go_first;
        end
    end

    // Registered output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_valid <= 1'b0;
            r_edge  <= '0;
            r_msg   <= '0;
        end else begin
            r_valid <= busy_q;
            if (busy_q) begin
                r_edge <= cnt_q;
                r_msg  <= sel_msg;
            end
        end
    end
endmodule

// File: rtl/crm_regen_chk.sv
// Property checker for crm_regen, attached by bind below.
module crm_regen_chk
    import crm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             busy_q,
    input logic             zero_q,
    input logic [ROW_W-1:0] row_q,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             r_valid,
    input logic [IDX_W-1:0] r_edge,
    input logic [MSG_W-1:0] r_msg
);
    a_r4_first_edge_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !$past(r_valid)) |-> (r_edge == '0));

    a_r4_edges_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && $past(r_valid)) |-> (r_edge == IDX_W'($past(r_edge) + 1'b1)));

    a_r4_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |=> !r_valid);

    a_r7_null_block_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && (int'(r_edge) < int'(row_q))) |-> (r_msg == '0));

    a_r8_first_pass_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && zero_q) |-> (r_msg == '0));

    a_r9_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) <= K_MAX);

    a_r6_no_most_negative: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> (r_msg != {1'b1, {MAG_W{1'b0}}}));
endmodule

bind crm_regen crm_regen_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_q   (busy_q),
    .zero_q   (zero_q),
    .row_q    (row_q),
    .fifo_cnt (fifo_cnt),
    .r_valid  (r_valid),
    .r_edge   (r_edge),
    .r_msg    (r_msg)
);

// File: tb/crm_regen_tb.sv
`timescale 1ns/1ps
module crm_regen_tb_top;
    import crm_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rec_wr = 1'b0, rec_sign = 1'b0;
    logic [SLOT_W-1:0] rec_slot = '0, go_slot = '0;
    logic [MAG_W-1:0]  rec_m1 = '0, rec_m2 = '0;
    logic [IDX_W-1:0]  rec_idx = '0;
    logic              sgn_push = 1'b0, sgn_bit = 1'b0;
    logic              go = 1'b0, go_first = 1'b0;
    logic [ROW_W-1:0]  go_row = '0;
    logic [KLEN_W-1:0] go_len = '0;
    logic              r_valid, busy;
    logic [IDX_W-1:0]  r_edge;
    logic [MSG_W-1:0]  r_msg;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    crm_regen dut_i (.*);

    // Behavioural reference state.
    int  m1_a[SLOTS], m2_a[SLOTS], idx_a[SLOTS], cs_a[SLOTS];
    bit  q[$];
    bit  m_busy, m_zero, e_valid;
    int  m_cnt, m_len, m_slot, m_row, e_edge, e_msg;
    string e_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
                m1_a[s] = 0; m2_a[s] = 0; idx_a[s] = 0; cs_a[s] = 0;
            end
            q.delete();
            m_busy = 0; m_cnt = 0; e_valid = 0; e_edge = 0; e_msg = 0;
            e_tag = "R1";
        end else begin
            automatic bit was_busy = m_busy;
            automatic int qn = q.size();
            if (m_busy) begin
                automatic bit qs = 0;
                automatic int mag, v;
                if (q.size() > 0) qs = q.pop_front();
                mag = (m_cnt == idx_a[m_slot]) ? m2_a[m_slot] : m1_a[m_slot];
                v = (cs_a[m_slot] != 0) ^ qs ? -mag : mag;
                if (m_zero)            begin v = 0; e_tag = "R8 R9"; end
                else if (m_cnt < m_row) begin v = 0; e_tag = "R7 R9"; end
                else e_tag = (m_cnt == idx_a[m_slot]) ? "R2 R5 R6 R9 R10" : "R2 R5 R6 R9 R10";
                e_valid = 1; e_edge = m_cnt; e_msg = v & ((1 << MSG_W) - 1);
                m_cnt++;
                if (m_cnt == m_len) m_busy = 0;
            end else begin
                e_valid = 0;
            end
            if (sgn_push && qn < K_MAX) q.push_back(sgn_bit);
            if (rec_wr) begin
                m1_a[rec_slot] = rec_m1; m2_a[rec_slot] = rec_m2;
                idx_a[rec_slot] = rec_idx; cs_a[rec_slot] = rec_sign;
            end
            if (go && !was_busy && go_len != 0 && go_len <= K_MAX) begin
                m_busy = 1; m_cnt = 0; m_len = go_len; m_slot = go_slot;
                m_row = go_row; m_zero = go_first;
            end
        end
    end

    // Every-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (r_valid !== e_valid || busy !== m_busy) begin
                errors++;
                $display("FAIL R3 R4 valid/busy: got %b/%b exp %b/%b at %0t",
                         r_valid, busy, e_valid, m_busy, $time);
            end else if (e_valid && (r_edge !== IDX_W'(e_edge) || r_msg !== MSG_W'(e_msg))) begin
                errors++;
                $display("FAIL %s edge/msg: got %0d/%0d exp %0d/%0d at %0t",
                         e_tag, r_edge, r_msg, e_edge, e_msg, $time);
            end
        end
    end

    task automatic wr_rec(int s, int a, int b, int ix, bit sg);
        @(negedge clk);
        rec_wr = 1; rec_slot = SLOT_W'(s); rec_m1 = MAG_W'(a); rec_m2 = MAG_W'(b);
        rec_idx = IDX_W'(ix); rec_sign = sg;
        @(negedge clk); rec_wr = 0;
    endtask

    task automatic push_bits(int n, int pattern);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sgn_push = 1; sgn_bit = pattern[i % 32];
        end
        @(negedge clk); sgn_push = 0;
    endtask

    task automatic start(int s, int row, int len, bit first);
        @(negedge clk);
        go = 1; go_slot = SLOT_W'(s); go_row = ROW_W'(row);
        go_len = KLEN_W'(len); go_first = first;
        @(negedge clk); go = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state seen at the ports.
        @(negedge clk);
        checks++;
        if (r_valid !== 1'b0 || busy !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got %b/%b exp 0/0", r_valid, busy);
        end
        // R1 R9: empty queue and zero record give all-zero messages.
        start(0, 0, 3, 0); wait_idle();
        // R2 R5 R6: mixed signs, minimum on edge 2.
        wr_rec(1, 3, 7, 2, 0);
        push_bits(6, 'b101101);
        start(1, 0, 6, 0); wait_idle();
        // R6: negative sign product.
        wr_rec(2, 15, 15, 0, 1);
        push_bits(4, 'b0110);
        start(2, 0, 4, 0); wait_idle();
        // R7: null-block edges below row 3 still pop signs.
        wr_rec(3, 5, 9, 4, 1);
        push_bits(8, 'b11001010);
        start(3, 3, 8, 0); wait_idle();
        // R8: first sub-iteration forces zero.
        push_bits(5, 'b11111);
        start(1, 0, 5, 1); wait_idle();
        // R9: overflow drops pushes beyond K_MAX; minimum on last edge.
        wr_rec(0, 2, 6, K_MAX - 1, 0);
        push_bits(K_MAX + 2, 32'h5A5A_F0F0);
        start(0, 0, K_MAX, 0); wait_idle();
        // R3: bad lengths ignored.
        start(1, 0, 0, 0); wait_idle();
        start(1, 0, K_MAX + 1, 0); wait_idle();
        // R3 R10: start while busy ignored; record rewrite mid-burst.
        push_bits(3, 'b010);
        start(3, 1, 10, 0);
        start(2, 0, 2, 0);
        wr_rec(3, 1, 4, 6, 0);
        push_bits(4, 'b1001);
        wait_idle();
        // R4: back-to-back bursts with a single idle gap.
        start(1, 2, 2, 0);
        @(negedge clk);
        start(2, 0, 3, 0);
        wait_idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule